// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns characters written over a small register port into asynchronous serial frames on one output line. A free-running counter, loaded from a 12-bit divisor, produces a sampling tick at sixteen times the bit rate. Sixteen ticks make one bit time. The line rests high. A frame starts with a low start bit, carries 5 to 9 data bits with the least significant bit first, may add an even or odd parity bit, and ends with one or two high stop bits.

Software writes characters into a one-entry holding register. A character moves into the shifter as soon as the shifter is free, and at the last tick of a frame when one is in flight, so consecutive characters leave with no idle time between them. Two status flags are available. One says the holding register can take a character. The other says the line has gone quiet with nothing left to send. Each flag drives its own interrupt line through an enable bit. The frame format is latched when each character is loaded, so it can be changed between characters.

Top module: `sertx_top`

## Requirements
- R1: After reset the line is high, the holding-empty flag is 1, the complete flag is 0, both interrupt lines are 0, the divisor is 0, the format is 8 data bits / no parity / one stop bit, and the transmitter is disabled.
- R2: Every frame is a low start bit, then the data bits least significant first, then the parity bit when parity is on, then the stop bits, which are high. The line is high between frames.
- R3: The format register (address 3) holds the character size in bits [2:0]. Code 0 gives 5 data bits, 1 gives 6, 2 gives 7, 3 gives 8 and 7 gives 9. The reserved codes 4, 5 and 6 send 8 bits. Data bits above the selected size are not sent. The ninth bit comes from `reg_wbit8` and is captured together with the data write.
- R4: Format bits [4:3] select parity. 2'b10 is even (the parity bit makes the number of ones even) and 2'b11 is odd. 2'b00 and the reserved 2'b01 send no parity bit.
- R5: Format bit [5] = 0 sends one stop bit and = 1 sends two.
- R6: A bit lasts 16 × (divisor + 1) clock cycles. Address 1 writes divisor bits [7:0]. Address 2 writes divisor bits [11:8] from write-data bits [3:0]; the upper write-data bits are ignored.
- R7: The holding-empty flag falls in the cycle after a character is accepted. It rises again when that character moves into the shifter.
- R8: When a character is waiting as a frame ends, its start bit begins in the very next bit slot, with no idle time.
- R9: The complete flag is set when a frame ends with the holding register empty. It is cleared by an accepted data write (address 0) or by writing the control register (address 4) with bit [3] = 1.
- R10: The empty interrupt follows the empty flag while control bit [1] is set. The complete interrupt follows the complete flag while control bit [2] is set. Both interrupts are registered one cycle behind the flag.
- R11: Control bit [0] enables the transmitter. A data write while it is 0 is dropped: the empty flag stays 1 and no frame appears, even after the transmitter is enabled again.
- R12: A data write while the holding register is full is dropped. The waiting character is not altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | 0 data, 1 divisor low, 2 divisor high, 3 format, 4 control |
| reg_wdata | input | 8 | Write data |
| reg_wbit8 | input | 1 | Ninth data bit, captured together with a data write |
| txd | output | 1 | Serial line, high when idle |
| tx_empty | output | 1 | Holding register can accept a character |
| tx_done | output | 1 | Transmission complete, nothing waiting |
| irq_empty | output | 1 | Empty interrupt request |
| irq_done | output | 1 | Complete interrupt request |

## Verification
The assertions assume the divisor is not rewritten while a tick is pending, because the tick-spacing property relates a tick to the divisor loaded on the previous cycle. They also assume that at most one register write happens per cycle. The bench writes the divisor and the format only when the line is quiet and the complete flag is set. It issues each write as a single-cycle strobe, so every frame is sent with one fixed format and one fixed bit time. A scoreboard builds each expected frame from the format in force at the write and compares it with the bits sampled mid-bit on the line. Dropped writes are never queued, so any frame they cause shows up as an unexpected frame.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  typedef struct packed {
    logic [2:0] size;
    logic [1:0] par;
    logic       two_stop;
  } fmt_t;

  localparam logic [2:0] ADDR_DATA  = 3'd0;
  localparam logic [2:0] ADDR_DIVLO = 3'd1;
  localparam logic [2:0] ADDR_DIVHI = 3'd2;
  localparam logic [2:0] ADDR_FMT   = 3'd3;
  localparam logic [2:0] ADDR_CTRL  = 3'd4;

  // Character size code to number of data bits; reserved codes fall back to 8.
  function automatic logic [3:0] size_bits(input logic [2:0] code);
    case (code)
      3'd0:    size_bits = 4'd5;
      3'd1:    size_bits = 4'd6;
      3'd2:    size_bits = 4'd7;
      3'd3:    size_bits = 4'd8;
      3'd7:    size_bits = 4'd9;
      default: size_bits = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic             tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= (cnt_q == '0);
      if (cnt_q == '0) cnt_q <= div;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick = tick_q;

  // R6: with a nonzero divisor, two ticks are never adjacent
  a_r6_tick_gap: assert property (@(posedge clk) disable iff (rst)
    (tick_q && ($past(div) != '0)) |=> !tick_q);

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          tx_en,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_word,
  input  fmt_t          fmt,
  input  logic          clr_done,
  output logic          txd,
  output logic          hold_empty,
  output logic          done
);

  localparam int OVS_W = $clog2(OVS);
  localparam int CNT_W = $clog2(DW + 1);

  tx_state_e        state_q, state_d;
  logic [DW-1:0]    sh_q, sh_d;
  logic [CNT_W-1:0] nbits_q, nbits_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             par_on_q, par_on_d;
  logic             par_bit_q, par_bit_d;
  logic             two_q, two_d;
  logic             stop2_q, stop2_d;
  logic [OVS_W-1:0] ovs_q, ovs_d;
  logic [DW-1:0]    hold_q;
  logic             hold_full_q;
  logic             done_q;
  logic             txd_q, line_d;

  logic             accept, bit_end, frame_end, load;
  logic [CNT_W-1:0] nb_load;
  logic [DW-1:0]    mask, masked;
  logic             par_load;

  assign accept    = wr_stb && tx_en && !hold_full_q;
  assign bit_end   = tick && (ovs_q == OVS_W'(OVS - 1));
  assign frame_end = (state_q == ST_STOP) && bit_end && (!two_q || stop2_q);
  assign load      = hold_full_q && tx_en && ((state_q == ST_IDLE) || frame_end);

  // Format decode for the character about to load
  assign nb_load = CNT_W'(size_bits(fmt.size));

  always_comb begin
    for (int i = 0; i < DW; i++) mask[i] = (i < int'(nb_load));
  end

  assign masked   = hold_q & mask;
  assign par_load = (^masked) ^ fmt.par[0];

  always_comb begin
    state_d   = state_q;
    sh_d      = sh_q;
    nbits_d   = nbits_q;
    idx_d     = idx_q;
    par_on_d  = par_on_q;
    par_bit_d = par_bit_q;
    two_d     = two_q;
    stop2_d   = stop2_q;
    ovs_d     = tick ? ovs_q + 1'b1 : ovs_q;
    case (state_q)
      ST_START: if (bit_end) begin
        state_d = ST_DATA;
        idx_d   = '0;
      end
      ST_DATA: if (bit_end) begin
        sh_d = sh_q >> 1;
        if (idx_q == nbits_q - 1'b1) begin
          state_d = par_on_q ? ST_PAR : ST_STOP;
          stop2_d = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_PAR: if (bit_end) begin
        state_d = ST_STOP;
        stop2_d = 1'b0;
      end
      ST_STOP: if (bit_end) begin
        if (two_q && !stop2_q) stop2_d = 1'b1;
        else                   state_d = ST_IDLE;
      end
      default: ;
    endcase
    if (load) begin
      state_d   = ST_START;
      sh_d      = hold_q;
      nbits_d   = nb_load;
      par_on_d  = fmt.par[1];
      par_bit_d = par_load;
      two_d     = fmt.two_stop;
      stop2_d   = 1'b0;
      ovs_d     = '0;
    end
  end

  always_comb begin
    case (state_d)
      ST_START: line_d = 1'b0;
      ST_DATA:  line_d = sh_d[0];
      ST_PAR:   line_d = par_bit_d;
      default:  line_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      sh_q      <= '0;
      nbits_q   <= '0;
      idx_q     <= '0;
      par_on_q  <= 1'b0;
      par_bit_q <= 1'b0;
      two_q     <= 1'b0;
      stop2_q   <= 1'b0;
      ovs_q     <= '0;
      txd_q     <= 1'b1;
    end else begin
      state_q   <= state_d;
      sh_q      <= sh_d;
      nbits_q   <= nbits_d;
      idx_q     <= idx_d;
      par_on_q  <= par_on_d;
      par_bit_q <= par_bit_d;
      two_q     <= two_d;
      stop2_q   <= stop2_d;
      ovs_q     <= ovs_d;
      txd_q     <= line_d;
    end
  end

  // Holding register and status flags
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      if (accept) begin
        hold_q      <= wr_word;
        hold_full_q <= 1'b1;
      end else if (load) begin
        hold_full_q <= 1'b0;
      end
      if (accept || clr_done)            done_q <= 1'b0;
      else if (frame_end && !hold_full_q) done_q <= 1'b1;
    end
  end

  assign txd        = txd_q;
  assign hold_empty = !hold_full_q;
  assign done       = done_q;

  // R2: the line is high throughout the stop bits
  a_r2_stop_high: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STOP) |-> txd_q);

  // R9: complete is only reported while the shifter is idle
  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (state_q == ST_IDLE));

  // R7: an idle, enabled shifter drains the holding register in one cycle
  a_r7_hold_drains: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && hold_full_q && tx_en) |=> !hold_full_q);

  // R12: a waiting character stays unchanged until it is loaded
  a_r12_hold_kept: assert property (@(posedge clk) disable iff (rst)
    (hold_full_q && !load) |=> (hold_full_q && $stable(hold_q)));

  // R8: a waiting character starts right at the end of the current frame
  a_r8_no_gap: assert property (@(posedge clk) disable iff (rst)
    (frame_end && hold_full_q && tx_en) |=> (state_q == ST_START && !txd_q));

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_wbit8,
  output logic              txd,
  output logic              tx_empty,
  output logic              tx_done,
  output logic              irq_empty,
  output logic              irq_done
);

  localparam int HI_W = DIV_W - DATA_W;
  localparam int DW   = DATA_W + 1;

  logic [DIV_W-1:0] div_q;
  fmt_t             fmt_q;
  logic             tx_en_q, ie_empty_q, ie_done_q;
  logic             irq_empty_q, irq_done_q;
  logic             tick, wr_stb, clr_done;
  logic             empty_w, done_w;

  assign wr_stb   = reg_wr && (reg_addr == ADDR_DATA);
  assign clr_done = reg_wr && (reg_addr == ADDR_CTRL) && reg_wdata[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q      <= '0;
      fmt_q      <= '{size: 3'd3, par: 2'b00, two_stop: 1'b0};
      tx_en_q    <= 1'b0;
      ie_empty_q <= 1'b0;
      ie_done_q  <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        ADDR_DIVLO: div_q[DATA_W-1:0]     <= reg_wdata;
        ADDR_DIVHI: div_q[DIV_W-1:DATA_W] <= reg_wdata[HI_W-1:0];
        ADDR_FMT: begin
          fmt_q.size     <= reg_wdata[2:0];
          fmt_q.par      <= reg_wdata[4:3];
          fmt_q.two_stop <= reg_wdata[5];
        end
        ADDR_CTRL: begin
          tx_en_q    <= reg_wdata[0];
          ie_empty_q <= reg_wdata[1];
          ie_done_q  <= reg_wdata[2];
        end
        default: ;
      endcase
    end
  end

  sertx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst  (rst),
    .div  (div_q),
    .tick (tick)
  );

  sertx_framer #(.OVS(OVS), .DW(DW)) u_framer (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .tx_en      (tx_en_q),
    .wr_stb     (wr_stb),
    .wr_word    ({reg_wbit8, reg_wdata}),
    .fmt        (fmt_q),
    .clr_done   (clr_done),
    .txd        (txd),
    .hold_empty (empty_w),
    .done       (done_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_empty_q <= 1'b0;
      irq_done_q  <= 1'b0;
    end else begin
      irq_empty_q <= empty_w && ie_empty_q;
      irq_done_q  <= done_w && ie_done_q;
    end
  end

  assign tx_empty  = empty_w;
  assign tx_done   = done_w;
  assign irq_empty = irq_empty_q;
  assign irq_done  = irq_done_q;

  // R10: an interrupt request needs its enable in the cycle before
  a_r10_irq_done: assert property (@(posedge clk) disable iff (rst)
    irq_done_q |-> $past(ie_done_q && done_w));
  a_r10_irq_empty: assert property (@(posedge clk) disable iff (rst)
    irq_empty_q |-> $past(ie_empty_q && empty_w));

  // R11: while disabled, the holding register cannot fill
  a_r11_off_no_fill: assert property (@(posedge clk) disable iff (rst)
    (!tx_en_q && empty_w) |=> empty_w);

endmodule

// File: tb/sertx_top_bench.sv
`timescale 1ns/1ps
module sertx_top_bench;

  typedef struct {
    logic [15:0] bits;
    int          len;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic       reg_wbit8 = 1'b0;
  logic       txd, tx_empty, tx_done, irq_empty, irq_done;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  int    bit_p = 16;
  int    mon_frames = 0;
  int    mon_gap = 0;
  int    prev_mid = -1;
  string cur_tag = "R2";
  bit    finished = 1'b0;
  exp_t  exp_q[$];
  int    edges[$];
  logic  prev_e = 1'b1;

  logic [2:0] cur_size = 3'd3;
  logic [1:0] cur_par = 2'b00;
  logic       cur_two = 1'b0;

  sertx_top u_sertx_top (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wbit8(reg_wbit8), .txd(txd),
    .tx_empty(tx_empty), .tx_done(tx_done), .irq_empty(irq_empty),
    .irq_done(irq_done)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (txd !== prev_e) edges.push_back(cyc);
    prev_e = txd;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic int nbits_of(input logic [2:0] c);
    if (c == 3'd7) return 9;
    if (c <= 3'd3) return 5 + int'(c);
    return 8;
  endfunction

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d, input logic b8);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_wbit8 = b8;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_fmt(input logic [2:0] sz, input logic [1:0] p, input logic two);
    cur_size = sz; cur_par = p; cur_two = two;
    reg_write(3'd3, {2'b00, two, p, sz}, 1'b0);
  endtask

  // Driver: queue the expected frame, then write the character
  task automatic send(input logic [8:0] w);
    exp_t e;
    int   nb;
    logic par;
    nb = nbits_of(cur_size);
    e.bits = '0; e.len = 0; par = 1'b0;
    for (int i = 0; i < nb; i++) begin
      e.bits[e.len] = w[i]; par = par ^ w[i]; e.len++;
    end
    if (cur_par == 2'b10) begin e.bits[e.len] = par;  e.len++; end
    if (cur_par == 2'b11) begin e.bits[e.len] = ~par; e.len++; end
    e.bits[e.len] = 1'b1; e.len++;
    if (cur_two) begin e.bits[e.len] = 1'b1; e.len++; end
    exp_q.push_back(e);
    reg_write(3'd0, w[7:0], w[8]);
  endtask

  task automatic wait_done(input int maxc);
    for (int i = 0; i < maxc && tx_done !== 1'b1; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // Monitor: decode frames mid-bit and compare with the scoreboard
  initial begin : monitor
    logic last;
    last = 1'b1;
    forever begin
      @(negedge clk);
      if (last === 1'b1 && txd === 1'b0) begin
        int          per;
        int          n;
        logic        st;
        logic [15:0] got;
        exp_t        e;
        per = bit_p;
        if (prev_mid >= 0) mon_gap = cyc - prev_mid;
        repeat (per / 2 - 1) @(negedge clk);
        st = txd;
        if (exp_q.size() == 0) begin
          n = 10; e.bits = '0; e.len = 0;
        end else begin
          e = exp_q.pop_front(); n = e.len;
        end
        got = '0;
        for (int i = 0; i < n; i++) begin
          repeat (per) @(negedge clk);
          got[i] = txd;
        end
        prev_mid = cyc;
        mon_frames++;
        if (e.len == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R11/R12 unexpected frame: actual %0h expected none", got);
        end else begin
          chk({cur_tag, " start bit"}, {31'd0, st}, 32'd0);
          chk({cur_tag, " frame bits"}, {16'd0, got}, {16'd0, e.bits});
        end
        last = txd;
      end else begin
        last = txd;
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stimulus
    int f0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 txd idle", {31'd0, txd}, 32'd1);
    chk("R1 empty", {31'd0, tx_empty}, 32'd1);
    chk("R1 done", {31'd0, tx_done}, 32'd0);
    chk("R1 irqs", {30'd0, irq_empty, irq_done}, 32'd0);

    reg_write(3'd1, 8'd2, 1'b0);
    bit_p = 48;
    reg_write(3'd4, 8'h01, 1'b0);

    // R6 and R2: 8N1 bit time from edges of 0x55
    cur_tag = "R2/R6 8N1";
    edges.delete();
    send(9'h055);
    // R7: empty low right after accept, then high once moved to the shifter
    chk("R7 empty after write", {31'd0, tx_empty}, 32'd0);
    chk("R9 done cleared by write", {31'd0, tx_done}, 32'd0);
    @(negedge clk);
    chk("R7 empty after load", {31'd0, tx_empty}, 32'd1);
    wait_done(2000);
    chk("R9 done after frame", {31'd0, tx_done}, 32'd1);
    if (edges.size() >= 3) chk("R6 bit period div=2", edges[2] - edges[1], 32'd48);
    else chk("R6 edge count", edges.size(), 32'd3);

    // R3: five bits, upper data ignored
    cur_tag = "R3 5N1"; set_fmt(3'd0, 2'b00, 1'b0); send(9'h1F3); wait_done(2000);
    // R4: even parity, 6 bits
    cur_tag = "R4 6E1"; set_fmt(3'd1, 2'b10, 1'b0); send(9'h02D); wait_done(2000);
    // R5 + R4: odd parity, two stop bits
    cur_tag = "R5 7O2"; set_fmt(3'd2, 2'b11, 1'b1); send(9'h045); wait_done(2000);
    // R3: ninth bit from reg_wbit8 with even parity
    cur_tag = "R3 9E1"; set_fmt(3'd7, 2'b10, 1'b0); send(9'h1A5); wait_done(2000);
    cur_tag = "R3 9N1"; set_fmt(3'd7, 2'b00, 1'b0); send(9'h0FF); wait_done(2000);
    // R3/R4 reserved codes: 8 bits, no parity
    cur_tag = "R3 reserved"; set_fmt(3'd5, 2'b01, 1'b0); send(9'h0C3); wait_done(2000);
    cur_tag = "R4 8O1 zero"; set_fmt(3'd3, 2'b11, 1'b0); send(9'h000); wait_done(2000);

    // R10: interrupts follow flags with enables
    reg_write(3'd4, 8'h07, 1'b0);
    repeat (2) @(negedge clk);
    chk("R10 irq_done", {31'd0, irq_done}, 32'd1);
    chk("R10 irq_empty", {31'd0, irq_empty}, 32'd1);
    reg_write(3'd4, 8'h0F, 1'b0);
    chk("R9 done cleared by control", {31'd0, tx_done}, 32'd0);
    @(negedge clk);
    chk("R10 irq_done drops", {31'd0, irq_done}, 32'd0);

    // R8/R12: back-to-back, third write dropped
    cur_tag = "R8 8E2"; set_fmt(3'd3, 2'b10, 1'b1);
    send(9'h0A5);
    repeat (3) @(negedge clk);
    send(9'h05A);
    chk("R7 empty while waiting", {31'd0, tx_empty}, 32'd0);
    reg_write(3'd0, 8'hFF, 1'b0);
    chk("R12 still full", {31'd0, tx_empty}, 32'd0);
    @(negedge clk);
    chk("R10 irq_empty low when full", {31'd0, irq_empty}, 32'd0);
    wait_done(4000);
    chk("R8 frames with no idle gap", (mon_gap >= 20 && mon_gap <= 28) ? 32'd1 : 32'd0, 32'd1);
    chk("R12 queue drained", exp_q.size(), 32'd0);

    // R11: writes while disabled are dropped
    reg_write(3'd4, 8'h00, 1'b0);
    f0 = mon_frames;
    reg_write(3'd0, 8'h3C, 1'b0);
    chk("R11 empty stays", {31'd0, tx_empty}, 32'd1);
    repeat (1500) @(negedge clk);
    reg_write(3'd4, 8'h01, 1'b0);
    repeat (1500) @(negedge clk);
    chk("R11 no frame", mon_frames - f0, 32'd0);
    chk("R11 empty after re-enable", {31'd0, tx_empty}, 32'd1);

    // R6: upper divisor field, upper write bits ignored -> divisor 0x100
    set_fmt(3'd3, 2'b00, 1'b0);
    reg_write(3'd1, 8'h00, 1'b0);
    reg_write(3'd2, 8'hF1, 1'b0);
    bit_p = 16 * 257;
    repeat (20) @(negedge clk);
    cur_tag = "R6 div=0x100";
    edges.delete();
    send(9'h055);
    wait_done(60000);
    if (edges.size() >= 3) chk("R6 bit period div=0x100", edges[2] - edges[1], 32'd4112);
    else chk("R6 edge count", edges.size(), 32'd3);
    chk("R2 all frames seen", exp_q.size(), 32'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule